// File: doc/BRIEF.md
# Cache Block Refill Controller with Selectable Memory Organization

This block fetches one cache block of four words from a modelled main memory. It can serve the refill in three ways. It can treat memory as one word wide, as two words wide, or as four independent banks that are accessed together. A refill begins with a start strobe and a block address. The controller then sends the address to the banks it needs. It waits out the fixed bank access time and returns the words to the cache. Each returned word carries its index within the block, so the cache knows where to place it. A single-cycle done pulse marks the last transfer.

Word i of a block always lives in bank i. Each bank model returns its word a fixed number of bus cycles after its access begins. The organization only decides how many banks start an access together and how many words move in one bus cycle. The two-word organization uses a second data lane for the upper word of each pair. The other two organizations use only the lower lane.

In the timing below, cycle 1 is the bus cycle that follows the clock edge at which the start strobe is taken. Cycle 1 is the address cycle. Accesses last 15 cycles and each transfer lasts one cycle.

Top module: `blk_fill_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `rsp_valid`, `rsp_pair` and `done` are low.
- R2: Mode code 0 (one word per access) runs four separate accesses. It delivers word 0, 1, 2, 3 in that order, one per transfer, in cycles 17, 33, 49 and 65, with `rsp_pair` low.
- R3: Mode code 1 (two words per access) runs two accesses. It makes one transfer in cycle 17 and another in cycle 33. Each transfer has `rsp_pair` high and `rsp_idx` equal to 0 and then 2. The lower lane carries word `rsp_idx` and the upper lane carries word `rsp_idx`+1.
- R4: Mode code 2 (interleaved banks) runs one parallel access in all banks. It then delivers words 0, 1, 2, 3 in consecutive cycles 17, 18, 19 and 20, with `rsp_pair` low.
- R5: Mode code 3 behaves exactly as mode code 0.
- R6: The data word for index i of block address A is (A << 8) | i, zero-extended to the data width. The upper lane reads zero when `rsp_pair` is low.
- R7: `busy` is high from cycle 1 through the cycle of the last transfer and is low in the cycle after it. `done` is high for exactly one cycle, coinciding with the last transfer.
- R8: A start strobe that arrives while `busy` is high is ignored. Any mode or address values presented with it are ignored too. The running fill keeps its timing and data, and no further fill follows it.
- R9: No bank returns its word earlier than 15 cycles after its access begins, so no mode makes its first transfer before cycle 17.
- R10: A start strobe given in the first cycle after `done` begins a new fill with the same timing as a start from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a block refill; taken only when idle |
| mode | input | 2 | Memory organization: 0 one word, 1 two words, 2 interleaved banks, 3 as 0 |
| blk_addr | input | ADDR_W | Block address, taken with start |
| busy | output | 1 | A refill is in progress |
| rsp_valid | output | 1 | A transfer occurs in this cycle |
| rsp_idx | output | IDX_W | Index within the block of the lower-lane word |
| rsp_data | output | DATA_W | Lower-lane word |
| rsp_pair | output | 1 | Upper lane also carries a word (two-word mode) |
| rsp_data_hi | output | DATA_W | Upper-lane word, index rsp_idx+1 |
| done | output | 1 | Last transfer of the block |

## Verification
A wrong state or word pointer inside the sequencer shows up at once as a transfer in the wrong cycle or with the wrong index. The very first transfer, in cycle 17, exposes it, and so does the first gap between transfers. A bank whose latency counter is wrong shifts the first transfer away from cycle 17. A fault in the bank data or in the lane select gives a word that does not match the block address and index, in the same cycle as the transfer. A start strobe that leaks into a running fill either changes the data or moves `done`. Failing that, it starts a second fill that shows up during the idle window that follows.

// File: rtl/fill_pkg.sv
// Shared types for the block refill controller.
// Assumes: two-bit mode code taken from the top-level port.
package fill_pkg;

    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_PAIR   = 2'd1,
        ORG_BANKED = 2'd2,
        ORG_RSVD   = 2'd3
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_ACC  = 2'd2,
        ST_XFER = 2'd3
    } fill_st_e;

endpackage

// File: rtl/fill_bank.sv
// Model of one memory bank with a fixed access latency.
// A go pulse latches the address and starts the access. The word is ready
// LAT cycles later, counting the cycle that follows the go edge as the first.
// The word stays ready until the next go.
// Assumes: LAT >= 1; DATA_W >= ADDR_W + TAG_W.
module fill_bank #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int LAT     = 15,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr,
    output logic              rdy,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam int TAG_W = 8;

    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic [DATA_W-1:0] data_q;

    // Access timer and stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            data_q <= '0;
        end else if (go) begin
            cnt_q  <= CNT_W'(LAT - 1);
            pend_q <= 1'b1;
            data_q <= DATA_W'({addr, TAG_W'(BANK_ID)});
        end else if (pend_q && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Word is presented once the access time has passed.
    always_comb begin
        rdy   = pend_q && (cnt_q == '0);
        rdata = data_q;
    end

    generate
        if (LAT > 1) begin : g_lat_chk
            AST_BANK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
                go |=> !rdy); // R9
        end
    endgenerate

    AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !go) |=> (rdy && $stable(rdata))); // R6

endmodule

// File: rtl/fill_seq.sv
// Sequencer for one block refill: address cycle, access wait, transfers.
// It picks which banks start an access and how far the word pointer steps,
// based on the organization latched at start.
// Assumes: N_WORDS is a power of two and at least 2; word i lives in bank i.
module fill_seq
    import fill_pkg::*;
#(
    parameter int N_WORDS = 4,
    parameter int IDX_W   = $clog2(N_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  org_e               mode_in,
    input  logic [N_WORDS-1:0] bank_rdy,
    output logic               busy,
    output logic               load,
    output logic [N_WORDS-1:0] go,
    output logic               xfer,
    output logic               pair,
    output logic [IDX_W-1:0]   widx,
    output logic               done
);
    fill_st_e         st_q, st_d;
    org_e             org_q, org_d;
    logic [IDX_W-1:0] wp_q, wp_d;
    logic [N_WORDS-1:0] cur_sel;
    logic             last;

    // Banks that one access covers, for a given organization and first word.
    function automatic logic [N_WORDS-1:0] sel_mask(org_e m, logic [IDX_W-1:0] w);
        case (m)
            ORG_PAIR:   return N_WORDS'(3) << w;
            ORG_BANKED: return '1;
            default:    return N_WORDS'(1) << w;
        endcase
    endfunction

    // State, organization and word pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            org_q <= ORG_NARROW;
            wp_q  <= '0;
        end else begin
            st_q  <= st_d;
            org_q <= org_d;
            wp_q  <= wp_d;
        end
    end

    // Next state, bank start pulses and transfer strobes.
    always_comb begin
        st_d    = st_q;
        org_d   = org_q;
        wp_d    = wp_q;
        go      = '0;
        load    = 1'b0;
        xfer    = 1'b0;
        pair    = 1'b0;
        done    = 1'b0;
        cur_sel = sel_mask(org_q, wp_q);
        last    = (org_q == ORG_PAIR) ? (wp_q == IDX_W'(N_WORDS - 2))
                                      : (wp_q == IDX_W'(N_WORDS - 1));
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    load  = 1'b1;
                    org_d = (mode_in == ORG_RSVD) ? ORG_NARROW : mode_in;
                    wp_d  = '0;
                    st_d  = ST_ADDR;
                end
            end
            ST_ADDR: begin
                go   = sel_mask(org_q, '0);
                st_d = ST_ACC;
            end
            ST_ACC: begin
                if ((bank_rdy & cur_sel) == cur_sel) st_d = ST_XFER;
            end
            ST_XFER: begin
                xfer = 1'b1;
                pair = (org_q == ORG_PAIR);
                if (last) begin
                    done = 1'b1;
                    st_d = ST_IDLE;
                end else begin
                    wp_d = wp_q + ((org_q == ORG_PAIR) ? IDX_W'(2) : IDX_W'(1));
                    if (org_q != ORG_BANKED) begin
                        go   = sel_mask(org_q, wp_d);
                        st_d = ST_ACC;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Drive status and pointer outputs.
    always_comb begin
        busy = (st_q != ST_IDLE);
        widx = wp_q;
    end

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(org_q)); // R8

    AST_XFER_BANK_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> bank_rdy[wp_q]); // R9

    AST_BANKED_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && org_q == ORG_BANKED && !done) |=> (xfer && wp_q == $past(wp_q) + IDX_W'(1))); // R4

    AST_NARROW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && org_q == ORG_NARROW && !done) |=> !xfer); // R2

    AST_NARROW_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (org_q == ORG_NARROW) |-> $onehot0(go)); // R2

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R7

endmodule

// File: rtl/blk_fill_ctrl.sv
// Top of the block refill controller. It holds the block address, runs the
// sequencer, instantiates one bank model per word, and steers the bank words
// onto the two response lanes.
// Assumes: DATA_W >= ADDR_W + 8; N_WORDS is a power of two.
module blk_fill_ctrl
    import fill_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int N_WORDS = 4,
    parameter int ACC_LAT = 15,
    parameter int IDX_W   = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_pair,
    output logic [DATA_W-1:0] rsp_data_hi,
    output logic              done
);
    logic [ADDR_W-1:0]  addr_q;
    logic               load;
    logic [N_WORDS-1:0] go;
    logic [N_WORDS-1:0] bank_rdy;
    logic [DATA_W-1:0]  bank_data [N_WORDS];
    logic               xfer;
    logic               pair;
    logic [IDX_W-1:0]   widx;

    // Block address register, loaded only when a fill is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (load) addr_q <= blk_addr;
    end

    fill_seq #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_in  (org_e'(mode)),
        .bank_rdy (bank_rdy),
        .busy     (busy),
        .load     (load),
        .go       (go),
        .xfer     (xfer),
        .pair     (pair),
        .widx     (widx),
        .done     (done)
    );

    generate
        for (genvar b = 0; b < N_WORDS; b++) begin : g_bank
            fill_bank #(
                .ADDR_W (ADDR_W),
                .DATA_W (DATA_W),
                .LAT    (ACC_LAT),
                .BANK_ID(b)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .go    (go[b]),
                .addr  (addr_q),
                .rdy   (bank_rdy[b]),
                .rdata (bank_data[b])
            );
        end
    endgenerate

    // Steer the addressed bank words onto the response lanes.
    always_comb begin
        rsp_valid   = xfer;
        rsp_pair    = pair;
        rsp_idx     = widx;
        rsp_data    = xfer ? bank_data[widx] : '0;
        rsp_data_hi = pair ? bank_data[widx + IDX_W'(1)] : '0;
    end

    AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_valid && (int'(rsp_idx) + (rsp_pair ? 2 : 1) == N_WORDS))); // R7

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy); // R7

endmodule

// File: tb/tb_blk_fill_ctrl.sv
`timescale 1ns/1ps
module tb_blk_fill_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode;
    logic [15:0] blk_addr;
    logic        busy, rsp_valid, rsp_pair, done;
    logic [1:0]  rsp_idx;
    logic [31:0] rsp_data, rsp_data_hi;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    blk_fill_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .blk_addr(blk_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .rsp_pair(rsp_pair), .rsp_data_hi(rsp_data_hi), .done(done)
    );

    // Stimulus table: {mode code, block address}.
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 16'h1234}, {2'd1, 16'hABCD}, {2'd2, 16'h0F0F},
        {2'd3, 16'h8001}, {2'd2, 16'hFFFF}, {2'd1, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int n_xfers(input int m);
        return (m == 1) ? 2 : 4;
    endfunction

    function automatic int exp_cyc(input int m, input int k);
        if (m == 2) return 17 + k;
        return 17 + 16 * k;
    endfunction

    function automatic string mreq(input int m);
        case (m)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [31:0] word_of(input logic [15:0] a, input int i);
        return 32'({a, 8'(i)});
    endfunction

    // Run one fill, starting at a negedge; ends at the negedge of the cycle after done.
    task automatic run_fill(input int m, input logic [15:0] a, input bit inject);
        int k = 0;
        int ndone = 0;
        int dn = exp_cyc(m, n_xfers(m) - 1);
        start = 1'b1; mode = 2'(m); blk_addr = a;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= dn + 1; n++) begin
            if (n == 1) chk(busy == 1'b1, "R7", busy, 1);
            if (rsp_valid) begin
                int ei = (m == 1) ? 2 * k : k;
                chk(n == exp_cyc(m, k), (k == 0) ? "R9" : mreq(m), n, exp_cyc(m, k));
                chk(int'(rsp_idx) == ei, mreq(m), rsp_idx, ei);
                chk(rsp_data == word_of(a, ei), "R6", rsp_data, word_of(a, ei));
                chk(rsp_pair == (m == 1), mreq(m), rsp_pair, (m == 1));
                if (m == 1)
                    chk(rsp_data_hi == word_of(a, ei + 1), "R3", rsp_data_hi, word_of(a, ei + 1));
                else
                    chk(rsp_data_hi == 32'h0, "R6", rsp_data_hi, 0);
                k++;
            end
            if (done) begin
                ndone++;
                chk(n == dn && rsp_valid, "R7", n, dn);
            end
            if (n == dn) chk(busy == 1'b1, "R7", busy, 1);
            if (n == dn + 1) chk(!busy && !rsp_valid, "R7", busy, 0);
            if (inject && n == 5) begin
                start = 1'b1; mode = 2'(2 - (m % 2)); blk_addr = ~a;
            end
            if (inject && n == 6) start = 1'b0;
            if (n <= dn) @(negedge clk);
        end
        chk(k == n_xfers(m), mreq(m), k, n_xfers(m));
        chk(ndone == 1, "R7", ndone, 1);
    endtask

    // Confirm no activity over an idle window.
    task automatic idle_chk(input int cycles, input string req);
        int seen = 0;
        for (int n = 0; n < cycles; n++) begin
            if (busy || rsp_valid || done) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = 2'd0; blk_addr = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !done && !rsp_pair, "R1", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !done && !rsp_pair, "R1", rsp_valid, 0);

        // Table walk, fills issued back to back (R10).
        for (int v = 0; v < 6; v++)
            run_fill(int'(VEC[v][17:16]), VEC[v][15:0], 1'b0);
        idle_chk(20, "R10");

        // Start strobes during a fill are ignored (R8), in each organization.
        run_fill(0, 16'h5A5A, 1'b1);
        idle_chk(80, "R8");
        run_fill(1, 16'h3C3C, 1'b1);
        idle_chk(80, "R8");
        run_fill(2, 16'h0001, 1'b1);
        idle_chk(80, "R8");

        // Reserved code behaves as one word per access (R5).
        run_fill(3, 16'h7777, 1'b0);

        // Reset in the middle of a fill returns to the quiet state (R1).
        start = 1'b1; mode = 2'd2; blk_addr = 16'h1111;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !rsp_valid && !done, "R1", busy, 0);
        idle_chk(30, "R1");
        run_fill(2, 16'h2222, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule